// File: doc/BRIEF.md
# Power-Fail Protected Byte-Wide Static Memory

This block is a synthesizable 2048 x 8 static memory. It presents the usual asynchronous byte-wide bus to the outside: an 11-bit address, data in and out, and active-low select, read-enable and write-strobe controls. A fast system clock samples the whole bus through a two-stage synchronizer. From the synchronized controls the block rebuilds the write window. The window opens when the later of select and write strobe goes low, and it closes when the earlier of them goes high. The byte on the data input at the close is committed to the address that was captured when the window opened.

A digital supply-good input stands in for a supply monitor. While it is low, the block drives nothing and accepts no write. Any window in progress is dropped without touching the array. Stored bytes survive the fault unchanged. After each committed write, the write strobe must stay released for a configurable number of clocks before a new window is accepted.

The external tri-state bus is split into separate data-in and data-out ports plus a drive-enable output. A pad ring or a wrapper combines them.

Top module: `pf_sram`

## Requirements
- R1: With supply good, select low, read-enable low and write strobe high, `dout_en` is 1 and `dout` carries the stored byte at `addr`. A change on the inputs reaches the outputs after the second rising clock edge, not the first.
- R2: In every other case `dout_en` is 0 and `dout` is 8'h00. This includes the reset state. It also covers the write strobe falling while a read is being driven, in which case the drive turns off two edges later.
- R3: A window exists only while both select and write strobe are low. It behaves the same whichever of the two falls first and whichever rises first. Each window commits exactly one byte when it closes.
- R4: The address is captured when the window opens, and later address changes inside the window do not redirect the write. The committed byte is the `din` value present at the moment the window closes.
- R5: After a commit, a window whose start arrives before the write strobe has been seen released for REC_CLKS (default 4) consecutive clocks is rejected. The array keeps its old byte even if the controls stay low. A window that starts after that interval is accepted.
- R6: While `supply_ok` is 0, `dout_en` is 0 in the same cycle, with no clock edge needed.
- R7: If `supply_ok` falls during an open window, that window is dropped and nothing is written. A window whose start falls inside a fault never commits, even if the supply returns before the controls are released.
- R8: Stored bytes are unchanged across a fault, and write attempts made during the fault have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of control state (not the array) |
| supply_ok | input | 1 | High when the supply is in tolerance |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data, 8'h00 when not driving |
| dout_en | output | 1 | High when the block should drive the bus |

## Verification
The bench goes after both orderings of the window edges. A design that used only one control to bound the window would write at the wrong moment or drop writes. It moves the address and the data inside an open window: a design that sampled the address late would write to the wrong byte, and one that took data at the open would store a stale value. It repeats a write too soon after a commit and holds the controls low through and past a supply fault. A design without recovery gating, or one that reopened a window on level instead of edge, would corrupt bytes that must survive. It also drops `supply_ok` in the middle of a read and checks that the drive stops in the same cycle rather than one edge later.

// File: rtl/pf_sram_pkg.sv
package pf_sram_pkg;

    // Write-window controller state
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

endpackage

// File: rtl/pf_sram_sync.sv
module pf_sram_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pf_sram_store.sv
module pf_sram_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);

    localparam int DEPTH = 1 << AW;

    // Array is deliberately not reset: its contents outlive faults and resets.
    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            cell_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = cell_q[rd_addr_i];

endmodule

// File: rtl/pf_sram_wctl.sv
module pf_sram_wctl
    import pf_sram_pkg::*;
#(
    parameter int AW       = 11,
    parameter int DW       = 8,
    parameter int REC_CLKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok_i,
    input  logic          sel_i,       // synchronized select, active high
    input  logic          strobe_i,    // synchronized write strobe, active high
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);

    localparam int              REC_W    = $clog2(REC_CLKS + 1);
    localparam logic [REC_W-1:0] REC_LOAD = REC_W'(REC_CLKS);

    typedef struct packed {
        win_state_e       state;
        logic             both_prev;
        logic [AW-1:0]    addr;
        logic [REC_W-1:0] rec;
    } wctl_t;

    wctl_t st_d, st_q;
    logic  both_low;
    logic  start_seen;
    logic  commit;

    always_comb begin
        both_low   = sel_i & strobe_i;
        start_seen = both_low & ~st_q.both_prev;
        commit     = (st_q.state == WIN_OPEN) & ~both_low & supply_ok_i;

        st_d           = st_q;
        st_d.both_prev = both_low;

        // recovery interval: counts released-strobe clocks after a commit
        if (commit) begin
            st_d.rec = REC_LOAD;
        end else if (st_q.rec != '0) begin
            st_d.rec = strobe_i ? REC_LOAD : st_q.rec - 1'b1;
        end

        unique case (st_q.state)
            WIN_IDLE: begin
                if (start_seen && supply_ok_i && st_q.rec == '0) begin
                    st_d.state = WIN_OPEN;
                    st_d.addr  = addr_i;
                end
            end
            WIN_OPEN: begin
                // fault aborts, release commits; both leave the window
                if (!supply_ok_i || !both_low) begin
                    st_d.state = WIN_IDLE;
                end
            end
            default: st_d.state = WIN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: WIN_IDLE, both_prev: 1'b0, addr: '0, rec: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o   = commit;
    assign wr_addr_o = st_q.addr;
    assign wr_data_o = data_i;

    // R3: a commit always ends the window and starts a full recovery interval
    a_r3_commit_closes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (st_q.state == WIN_IDLE) && (st_q.rec == REC_LOAD));

    // R4: captured address cannot move while the window stays open
    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == WIN_OPEN && $past(st_q.state) == WIN_OPEN) |-> $stable(st_q.addr));

    // R5: no window opens while recovery is still running
    a_r5_recovery_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == WIN_IDLE && st_q.rec != '0) |=> st_q.state == WIN_IDLE);

    // R7: a fault during an open window drops it
    a_r7_fault_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == WIN_OPEN && !supply_ok_i) |=> st_q.state == WIN_IDLE);

endmodule

// File: rtl/pf_sram.sv
module pf_sram #(
    parameter int AW       = 11,
    parameter int DW       = 8,
    parameter int REC_CLKS = 4,
    parameter int SYNC_STG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    localparam int            BW       = 3 + AW + DW;
    localparam logic [BW-1:0] BUS_IDLE = {3'b111, {(AW + DW){1'b0}}};

    logic [BW-1:0] bus_raw, bus_s;
    logic          s_cs_n, s_oe_n, s_we_n;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_din;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          drive;

    // whole bus delayed together so address and data stay aligned with controls
    assign bus_raw = {cs_n, oe_n, we_n, addr, din};

    pf_sram_sync #(
        .W       (BW),
        .STAGES  (SYNC_STG),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (bus_raw),
        .sync_o (bus_s)
    );

    assign {s_cs_n, s_oe_n, s_we_n, s_addr, s_din} = bus_s;

    pf_sram_wctl #(
        .AW       (AW),
        .DW       (DW),
        .REC_CLKS (REC_CLKS)
    ) u_wctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok),
        .sel_i       (~s_cs_n),
        .strobe_i    (~s_we_n),
        .addr_i      (s_addr),
        .data_i      (s_din),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data)
    );

    pf_sram_store #(
        .AW (AW),
        .DW (DW)
    ) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (s_addr),
        .rd_data_o (rd_data)
    );

    // supply_ok is used live so a fault floats the bus without waiting for a clock
    assign drive   = supply_ok & ~s_cs_n & ~s_oe_n & s_we_n;
    assign dout_en = drive;
    assign dout    = drive ? rd_data : '0;

    // R6: no drive during a supply fault
    a_r6_fault_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !dout_en);

endmodule

// File: tb/pf_sram_bench.sv
module pf_sram_bench;

    localparam int AW  = 11;
    localparam int DW  = 8;
    localparam int REC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b1;
    logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    pf_sram #(.AW(AW), .DW(DW), .REC_CLKS(REC)) u_pf_sram (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          mem_m [0:2047];
    bit          p1_cs, p1_oe, p1_we, p2_cs, p2_oe, p2_we;
    int          p1_a, p2_a, p1_d, p2_d;
    bit          m_open, m_prev;
    int          m_addr, m_rec;

    initial for (int i = 0; i < 2048; i++) mem_m[i] = -1;

    always @(posedge clk) begin
        if (!rst_n) begin
            {p1_cs, p1_oe, p1_we, p2_cs, p2_oe, p2_we} = '0;
            m_open = 0; m_prev = 0; m_rec = 0; m_addr = 0;
        end else begin
            bit act;
            bit done;
            int rec_before;
            act        = p2_cs && p2_we;
            rec_before = m_rec;
            done       = m_open && supply_ok && !act;
            if (done) mem_m[m_addr] = p2_d;
            if (done)            m_rec = REC;
            else if (m_rec > 0)  m_rec = p2_we ? REC : m_rec - 1;
            if (m_open) begin
                if (!supply_ok || !act) m_open = 0;
            end else if (act && !m_prev && supply_ok && rec_before == 0) begin
                m_open = 1;
                m_addr = p2_a;
            end
            m_prev = act;
            p2_cs = p1_cs; p2_oe = p1_oe; p2_we = p1_we; p2_a = p1_a; p2_d = p1_d;
            p1_cs = !cs_n; p1_oe = !oe_n; p1_we = !we_n; p1_a = addr; p1_d = din;
        end
    end

    // per-cycle comparison, 5 ns after the falling edge
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            bit exp_en;
            exp_en = supply_ok && p2_cs && p2_oe && !p2_we;
            chk(dout_en == exp_en, "R2 model drive-enable", dout_en, exp_en);
            if (!exp_en)
                chk(dout == 8'h00, "R2 model idle data", dout, 0);
            else if (mem_m[p2_a] >= 0)
                chk(dout == mem_m[p2_a][7:0], "R1 model read data", dout, mem_m[p2_a]);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // first_we: which control falls first; close_we: which rises first
    task automatic write_byte(input int a, input int d, input bit first_we, input bit close_we);
        @(negedge clk);
        addr = a[AW-1:0]; din = d[DW-1:0]; oe_n = 1'b1;
        if (first_we) we_n = 1'b0; else cs_n = 1'b0;
        @(negedge clk);
        if (first_we) cs_n = 1'b0; else we_n = 1'b0;
        idle(3);
        if (close_we) we_n = 1'b1; else cs_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        idle(REC + 4);
    endtask

    task automatic read_check(input int a, input int exp, input string req);
        @(negedge clk);
        addr = a[AW-1:0]; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk); #5;
        chk(dout_en == 1'b0, "R1 latency first edge", dout_en, 0);
        @(negedge clk); #5;
        chk(dout_en == 1'b1, "R1 drive after second edge", dout_en, 1);
        chk(dout == exp[7:0], req, dout, exp);
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1;
        idle(3);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        idle(3); #5;
        chk(dout_en == 1'b0, "R2 reset drive-enable", dout_en, 0);
        chk(dout == 8'h00, "R2 reset data", dout, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        // R3: all four edge orderings
        write_byte(11'h005, 8'hA5, 0, 0);
        write_byte(11'h7FF, 8'h3C, 1, 1);
        write_byte(11'h000, 8'h01, 0, 1);
        write_byte(11'h101, 8'h33, 1, 0);
        read_check(11'h005, 8'hA5, "R3 select-first/select-last");
        read_check(11'h7FF, 8'h3C, "R3 strobe-first/strobe-last");
        read_check(11'h000, 8'h01, "R3 select-first/strobe-last");
        read_check(11'h101, 8'h33, "R3 strobe-first/select-last");

        // R4: address moves and data changes inside an open window
        @(negedge clk);
        addr = 11'h020; din = 8'h11; cs_n = 1'b0; we_n = 1'b0;
        idle(4);
        addr = 11'h021; din = 8'h5A;
        idle(3);
        we_n = 1'b1; cs_n = 1'b1;
        idle(REC + 4);
        read_check(11'h020, 8'h5A, "R4 captured address, data at close");
        write_byte(11'h021, 8'h77, 0, 0);
        read_check(11'h021, 8'h77, "R4 moved address untouched by earlier window");

        // R5: second window too soon after a commit is rejected
        @(negedge clk);
        addr = 11'h100; din = 8'h11; cs_n = 1'b0; we_n = 1'b0;
        idle(3);
        we_n = 1'b1;
        @(negedge clk);
        addr = 11'h101; din = 8'h22; we_n = 1'b0;
        idle(5);
        we_n = 1'b1; cs_n = 1'b1;
        idle(REC + 4);
        read_check(11'h100, 8'h11, "R5 first write kept");
        read_check(11'h101, 8'h33, "R5 early window rejected");
        write_byte(11'h101, 8'h44, 1, 1);
        read_check(11'h101, 8'h44, "R5 window after interval accepted");

        // R2: strobe falls while a read is driven
        @(negedge clk);
        addr = 11'h005; din = 8'hA5; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        idle(2); #5;
        chk(dout_en == 1'b1 && dout == 8'hA5, "R2 read before strobe", dout, 8'hA5);
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); #5;
        chk(dout_en == 1'b1, "R2 drive one edge after strobe", dout_en, 1);
        @(negedge clk); #5;
        chk(dout_en == 1'b0, "R2 drive off two edges after strobe", dout_en, 0);
        @(negedge clk); we_n = 1'b1; cs_n = 1'b1; oe_n = 1'b1;
        idle(REC + 4);

        // R6: fault in the middle of a read floats at once
        @(negedge clk);
        addr = 11'h7FF; cs_n = 1'b0; oe_n = 1'b0;
        idle(2); #5;
        chk(dout_en == 1'b1, "R6 read driving before fault", dout_en, 1);
        @(negedge clk); supply_ok = 1'b0; #5;
        chk(dout_en == 1'b0, "R6 same-cycle float", dout_en, 0);
        chk(dout == 8'h00, "R6 data zero in fault", dout, 0);
        @(negedge clk); supply_ok = 1'b1; #5;
        chk(dout_en == 1'b1 && dout == 8'h3C, "R6 drive resumes", dout, 8'h3C);
        @(negedge clk); cs_n = 1'b1; oe_n = 1'b1;
        idle(3);

        // R7: fault during an open window aborts it
        @(negedge clk);
        addr = 11'h005; din = 8'hEE; cs_n = 1'b0; we_n = 1'b0;
        idle(5);
        supply_ok = 1'b0;
        idle(2);
        supply_ok = 1'b1;
        idle(3);
        we_n = 1'b1; cs_n = 1'b1;
        idle(REC + 4);
        read_check(11'h005, 8'hA5, "R7 aborted window wrote nothing");

        // R7/R8: window started in fault, supply back before release
        @(negedge clk);
        supply_ok = 1'b0;
        addr = 11'h7FF; din = 8'h00;
        @(negedge clk); cs_n = 1'b0; we_n = 1'b0;
        idle(4);
        supply_ok = 1'b1;
        idle(4);
        we_n = 1'b1; cs_n = 1'b1;
        idle(REC + 4);
        read_check(11'h7FF, 8'h3C, "R7 window started in fault never commits");

        // R8: long fault with repeated write attempts
        @(negedge clk); supply_ok = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            addr = 11'h020; din = 8'(k); cs_n = 1'b0; we_n = 1'b0;
            idle(3);
            we_n = 1'b1; cs_n = 1'b1;
            idle(2);
        end
        idle(REC + 4);
        @(negedge clk); supply_ok = 1'b1;
        idle(3);
        read_check(11'h020, 8'h5A, "R8 byte kept across fault");
        read_check(11'h101, 8'h44, "R8 other byte kept across fault");

        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule